// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This unit sits between the execute stage of a 32-bit RISC datapath and a word-organised data memory. It adds a sign-extended 16-bit displacement to a 32-bit base register value to form a byte address. It then turns each word, halfword or byte access into a word-level memory request. Byte order is big-endian: byte offset 0 within a word is its most significant byte.

On a store, the unit copies the low byte or halfword of the source register into every lane of the memory write data. A 4-bit byte-enable then selects the lane or lanes that actually change. On a load, the memory returns the addressed word in the cycle after the request. The unit picks out the addressed byte or halfword, right-justifies it, and sign- or zero-extends it to 32 bits. A halfword or word access whose address is not naturally aligned raises a misalign flag. Such an access issues no memory request and enables no byte lane.

Top module: `lsu_be`

## Requirements
- R1: The effective address equals `base_i` plus `offset_i` sign-extended to 32 bits, modulo 2^32. `mem_addr_o` carries bits 31:2 of that address.
- R2: The size code is 00 for byte, 01 for halfword, 10 for word, and 11 is handled as word. With `req_i` high, `misalign_o` is 1 exactly when a halfword has address bit 0 set, or a word has either of address bits 1:0 set. A byte access is never misaligned.
- R3: While `misalign_o` is 1, `mem_req_o` is 0 and `mem_be_o` is 0000.
- R4: An aligned byte store sets exactly one enable bit, where bit 3 is the lane for bits 31:24. Address bits 1:0 of 0, 1, 2 and 3 give `mem_be_o` 1000, 0100, 0010 and 0001.
- R5: A halfword store at address bits 1:0 = 0 gives `mem_be_o` 1100, and at 2 gives 0011. A word store gives 1111.
- R6: Store write data is replicated. A byte store drives {4{wdata[7:0]}}, a halfword store drives {2{wdata[15:0]}}, and a word store drives `wdata_i` unchanged.
- R7: An aligned load request raises `rvalid_o` in the next cycle only. `rdata_o` is then formed from `mem_rdata_i` as presented in that cycle.
- R8: A byte load at address bits 1:0 = k returns `mem_rdata_i` bits [31-8k -: 8] in `rdata_o[7:0]`.
- R9: A halfword load at address bits 1:0 = 0 returns bits 31:16, and at 2 returns bits 15:0, in `rdata_o[15:0]`.
- R10: If `unsigned_i` was 0 at request, the bits above the loaded byte or halfword copy its top bit. If it was 1, those bits are zero.
- R11: A word load returns `mem_rdata_i` unchanged.
- R12: While `rst_ni` is low, `rvalid_o` is 0.
- R13: A load request (`we_i` = 0) drives `mem_be_o` to 0000 and `mem_we_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | Access size code |
| unsigned_i | input | 1 | Zero-extend the load result |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| wdata_i | input | 32 | Store source register |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 30 | Word address |
| mem_be_o | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| mem_rdata_i | input | 32 | Read word, one cycle after request |
| misalign_o | output | 1 | Misaligned access flag |
| rvalid_o | output | 1 | Load result valid |
| rdata_o | output | 32 | Extended load result |

## Verification
Some properties are checked on every cycle. A misaligned access must leave the memory untouched. A load must never enable a lane. An aligned byte store must enable exactly one lane. No aligned word request may carry nonzero low address bits. The valid strobe must follow exactly one cycle after each accepted load, and every byte load must show a correct sign or zero fill. Only the directed scenarios can confirm the actual data content. These cover the choice of lane for each byte and halfword offset, the replicated store data, displacement arithmetic with negative offsets, and result values for positive and negative sample bytes.

// File: rtl/lsu_be_pkg.sv
package lsu_be_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic [1:0] ofs;
    acc_size_e  size;
    logic       uns;
  } load_ctrl_t;
endpackage

// File: rtl/lsu_be_agen.sv
module lsu_be_agen
  import lsu_be_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int OFS_W  = 2
) (
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [OFF_W-1:0]        offset_i,
  input  acc_size_e               size_i,
  output logic [ADDR_W-OFS_W-1:0] word_addr_o,
  output logic [OFS_W-1:0]        lane_ofs_o,
  output logic                    misalign_o
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] ea;

  assign ea          = base_i + {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
  assign word_addr_o = ea[ADDR_W-1:OFS_W];
  assign lane_ofs_o  = ea[OFS_W-1:0];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = ea[0];
      default: misalign_o = |ea[OFS_W-1:0];
    endcase
  end
endmodule

// File: rtl/lsu_be_store_lanes.sv
module lsu_be_store_lanes
  import lsu_be_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  en_i,
  input  acc_size_e             size_i,
  input  logic [1:0]            ofs_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W/8-1:0]   be_o,
  output logic [DATA_W-1:0]     wdata_o
);
  localparam int NL = DATA_W / 8;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    // big-endian: lane l holds byte offset NL-1-l
    localparam logic [1:0] BOFS = 2'(NL - 1 - l);
    logic hit;

    always_comb begin
      unique case (size_i)
        SZ_BYTE: hit = (ofs_i == BOFS);
        SZ_HALF: hit = (ofs_i[1] == BOFS[1]);
        default: hit = 1'b1;
      endcase
    end

    assign be_o[l] = en_i & hit;

    always_comb begin
      unique case (size_i)
        SZ_BYTE: wdata_o[l*8 +: 8] = wdata_i[7:0];
        SZ_HALF: wdata_o[l*8 +: 8] = wdata_i[(l%2)*8 +: 8];
        default: wdata_o[l*8 +: 8] = wdata_i[l*8 +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_be_load_align.sv
module lsu_be_load_align
  import lsu_be_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  acc_size_e         size_i,
  input  logic [1:0]        ofs_i,
  input  logic              uns_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int NL = DATA_W / 8;
  localparam int NH = NL / 2;

  load_ctrl_t ctrl_q;
  logic       vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      ctrl_q <= '{ofs: 2'b00, size: SZ_WORD, uns: 1'b0};
    end else begin
      vld_q <= capture_i;
      if (capture_i) ctrl_q <= '{ofs: ofs_i, size: size_i, uns: uns_i};
    end
  end

  logic [7:0]  byte_v;
  logic [15:0] half_v;
  logic [1:0]  byte_lane;
  logic        half_lane;

  assign byte_lane = 2'(NL - 1) - ctrl_q.ofs;
  assign half_lane = 1'(NH - 1) ^ ctrl_q.ofs[1];
  assign byte_v    = mem_rdata_i[byte_lane*8 +: 8];
  assign half_v    = mem_rdata_i[half_lane*16 +: 16];

  always_comb begin
    unique case (ctrl_q.size)
      SZ_BYTE: rdata_o = {{(DATA_W-8){byte_v[7] & ~ctrl_q.uns}}, byte_v};
      SZ_HALF: rdata_o = {{(DATA_W-16){half_v[15] & ~ctrl_q.uns}}, half_v};
      default: rdata_o = mem_rdata_i;
    endcase
  end

  assign rvalid_o = vld_q;

  AST_RVALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> rvalid_o); // R7
  AST_RVALID_ONLY_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> !rvalid_o); // R7
  AST_BYTE_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && ctrl_q.uns && ctrl_q.size == SZ_BYTE) |-> rdata_o[DATA_W-1:8] == '0); // R10
  AST_BYTE_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !ctrl_q.uns && ctrl_q.size == SZ_BYTE)
      |-> rdata_o[DATA_W-1:8] == {(DATA_W-8){rdata_o[7]}}); // R10
endmodule

// File: rtl/lsu_be.sv
module lsu_be
  import lsu_be_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  size_i,
  input  logic        unsigned_i,
  input  logic [31:0] base_i,
  input  logic [15:0] offset_i,
  input  logic [31:0] wdata_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [29:0] mem_addr_o,
  output logic [3:0]  mem_be_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  output logic        misalign_o,
  output logic        rvalid_o,
  output logic [31:0] rdata_o
);
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 16;
  localparam int OFS_W  = $clog2(DATA_W / 8);

  acc_size_e  size;
  logic       agen_mis;
  logic [1:0] lane_ofs;
  logic       ok;

  assign size = acc_size_e'(size_i);

  lsu_be_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .OFS_W(OFS_W)) u_agen (
    .base_i      (base_i),
    .offset_i    (offset_i),
    .size_i      (size),
    .word_addr_o (mem_addr_o),
    .lane_ofs_o  (lane_ofs),
    .misalign_o  (agen_mis)
  );

  assign misalign_o = req_i & agen_mis;
  assign ok         = req_i & ~agen_mis;
  assign mem_req_o  = ok;
  assign mem_we_o   = ok & we_i;

  lsu_be_store_lanes #(.DATA_W(DATA_W)) u_store (
    .en_i    (ok & we_i),
    .size_i  (size),
    .ofs_i   (lane_ofs),
    .wdata_i (wdata_i),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );

  lsu_be_load_align #(.DATA_W(DATA_W)) u_load (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .capture_i   (ok & ~we_i),
    .size_i      (size),
    .ofs_i       (lane_ofs),
    .uns_i       (unsigned_i),
    .mem_rdata_i (mem_rdata_i),
    .rvalid_o    (rvalid_o),
    .rdata_o     (rdata_o)
  );

  AST_MISALIGN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (mem_be_o == 4'b0000 && !mem_req_o)); // R3
  AST_LOAD_NO_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |-> (mem_be_o == 4'b0000 && !mem_we_o)); // R13
  AST_BYTE_BE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && size == SZ_BYTE) |-> $countones(mem_be_o) == 1); // R4
  AST_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && size == SZ_WORD) |-> lane_ofs == 2'b00); // R2
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> !rvalid_o); // R12
endmodule

// File: tb/lsu_be_tb.sv
module lsu_be_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, unsigned_i = 1'b0;
  logic [1:0]  size_i = 2'b00;
  logic [31:0] base_i = '0, wdata_i = '0, mem_rdata_i = '0;
  logic [15:0] offset_i = '0;
  logic        mem_req_o, mem_we_o, misalign_o, rvalid_o;
  logic [29:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o, rdata_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lsu_be u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [1:0] sz, input logic uns,
                       input logic [31:0] base, input logic [15:0] off, input logic [31:0] wd);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; size_i = sz; unsigned_i = uns;
    base_i = base; offset_i = off; wdata_i = wd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  function automatic logic [31:0] exp_load(input logic [1:0] sz, input logic uns,
                                           input logic [1:0] k, input logic [31:0] w);
    logic [7:0] b; logic [15:0] h;
    b = w[31 - 8*k -: 8];
    h = k[1] ? w[15:0] : w[31:16];
    case (sz)
      2'b00:   return uns ? {24'h0, b} : {{24{b[7]}}, b};
      2'b01:   return uns ? {16'h0, h} : {{16{h[15]}}, h};
      default: return w;
    endcase
  endfunction

  task automatic t_reset();
    chk("R12 rvalid in reset", {31'b0, rvalid_o}, 32'h0);
  endtask

  task automatic t_addr();
    drive(1'b0, 2'b10, 1'b0, 32'h1200_4094, 16'd24, '0);
    chk("R1 positive offset", {2'b0, mem_addr_o}, 32'h1200_40AC >> 2);
    drive(1'b0, 2'b10, 1'b0, 32'h0000_0100, 16'hFFFC, '0);
    chk("R1 negative offset", {2'b0, mem_addr_o}, 32'h0000_00FC >> 2);
    drive(1'b0, 2'b00, 1'b0, 32'h0000_0002, 16'h8000, '0);
    chk("R1 wrap", {2'b0, mem_addr_o}, 32'hFFFF_8002 >> 2);
    idle();
  endtask

  task automatic t_store_byte();
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 2'b00, 1'b0, 32'h0000_1000 + k, 16'd0, 32'hAABB_CC5A);
      chk("R4 byte be", {28'b0, mem_be_o}, 32'(4'b1000 >> k));
      chk("R6 byte data", mem_wdata_o, 32'h5A5A_5A5A);
      chk("R2 byte aligned", {31'b0, misalign_o}, 32'h0);
    end
    idle();
  endtask

  task automatic t_store_half_word();
    drive(1'b1, 2'b01, 1'b0, 32'h0000_2000, 16'd0, 32'h1122_3344);
    chk("R5 half be ofs0", {28'b0, mem_be_o}, 32'hC);
    chk("R6 half data", mem_wdata_o, 32'h3344_3344);
    drive(1'b1, 2'b01, 1'b0, 32'h0000_2000, 16'd2, 32'h1122_3344);
    chk("R5 half be ofs2", {28'b0, mem_be_o}, 32'h3);
    drive(1'b1, 2'b10, 1'b0, 32'h0000_2000, 16'd4, 32'h1122_3344);
    chk("R5 word be", {28'b0, mem_be_o}, 32'hF);
    chk("R6 word data", mem_wdata_o, 32'h1122_3344);
    chk("R5 word we", {31'b0, mem_we_o}, 32'h1);
    idle();
  endtask

  task automatic t_misalign();
    for (int k = 1; k < 4; k++) begin
      drive(1'b1, 2'b10, 1'b0, 32'h0000_3000, 16'(k), 32'hFFFF_FFFF);
      chk("R2 word misalign", {31'b0, misalign_o}, 32'h1);
      chk("R3 word no be", {28'b0, mem_be_o}, 32'h0);
      chk("R3 word no req", {31'b0, mem_req_o}, 32'h0);
    end
    drive(1'b1, 2'b01, 1'b0, 32'h0000_3000, 16'd3, 32'hFFFF_FFFF);
    chk("R2 half misalign", {31'b0, misalign_o}, 32'h1);
    chk("R3 half no be", {28'b0, mem_be_o}, 32'h0);
    drive(1'b1, 2'b01, 1'b0, 32'h0000_3000, 16'd2, 32'hFFFF_FFFF);
    chk("R2 half aligned", {31'b0, misalign_o}, 32'h0);
    drive(1'b0, 2'b10, 1'b0, 32'h0000_3002, 16'd0, '0);
    @(negedge clk_i);
    req_i = 1'b0; #1;
    chk("R7 no rvalid after misaligned load", {31'b0, rvalid_o}, 32'h0);
  endtask

  task automatic run_load(input logic [1:0] sz, input logic uns, input logic [1:0] k,
                          input logic [31:0] word, input string tag);
    drive(1'b0, sz, uns, 32'h0000_4000, 16'(k), '0);
    chk("R13 load be", {28'b0, mem_be_o}, 32'h0);
    chk("R13 load we", {31'b0, mem_we_o}, 32'h0);
    @(negedge clk_i);
    req_i = 1'b0; unsigned_i = ~uns; size_i = 2'b11; mem_rdata_i = word; #1;
    chk("R7 rvalid", {31'b0, rvalid_o}, 32'h1);
    chk(tag, rdata_o, exp_load(sz, uns, k, word));
    @(negedge clk_i); #1;
    chk("R7 rvalid drops", {31'b0, rvalid_o}, 32'h0);
  endtask

  task automatic t_loads();
    for (int k = 0; k < 4; k++) begin
      run_load(2'b00, 1'b0, 2'(k), 32'h8192_A3B4, "R8 R10 signed byte neg");
      run_load(2'b00, 1'b1, 2'(k), 32'h8192_A3B4, "R8 R10 unsigned byte");
      run_load(2'b00, 1'b0, 2'(k), 32'h1234_5678, "R8 R10 signed byte pos");
    end
    run_load(2'b01, 1'b0, 2'd0, 32'h8192_23B4, "R9 R10 signed half ofs0");
    run_load(2'b01, 1'b0, 2'd2, 32'h8192_A3B4, "R9 R10 signed half ofs2");
    run_load(2'b01, 1'b1, 2'd2, 32'h8192_A3B4, "R9 R10 unsigned half");
    run_load(2'b01, 1'b0, 2'd2, 32'h8192_23B4, "R9 positive half");
    run_load(2'b10, 1'b0, 2'd0, 32'hDEAD_BEEF, "R11 word load");
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    #1 t_reset();
    rst_ni = 1'b1;
    t_addr();
    t_store_byte();
    t_store_half_word();
    t_misalign();
    t_loads();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule